// File: doc/BRIEF.md
# Nibble Table Multiplier

This block multiplies two unsigned 8-bit operands without an adder array of partial-product bits. It splits each operand into its upper and lower 4-bit halves. Each of the four half-by-half pairings is read from a small product table. The four table outputs are shifted by their nibble weight and added to form a 16-bit product.

A caller presents both operands together with a strobe. One clock later the product appears on a register, and a valid flag shows that it is there. The table contents are computed when the design is elaborated, so the block needs no memory file. The operand width is a parameter, given as nibble width times nibble count. The default is 8 bits.

Top module: `nibble_lut_mult`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_prod` is 0.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge, with a latency of exactly one cycle.
- R3: When `in_valid` is 1 at a rising edge, `out_prod` after that edge equals the unsigned product `op_a * op_b` of the operands sampled at that edge.
- R4: When `in_valid` is 0 at a rising edge, `out_prod` keeps its value, whatever the operands are.
- R5: Each half-by-half table returns the plain unsigned product of its two 4-bit indices. For example, (1,1) gives 1, (3,3) gives 9 and (15,15) gives 225.
- R6: The four partial products are weighted as follows: low×low by 1, low×high and high×low by 16, and high×high by 256.
- R7: The largest operands, 255 × 255, give 65025 (0xFE01), and a zero operand gives 0. The result never exceeds 65025.
- R8: Strobes on consecutive cycles each produce their own product on consecutive cycles, with no bubble. All 65536 operand pairs are correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; loads the product register |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| out_valid | output | 1 | Product valid, one cycle after the strobe |
| out_prod | output | 16 | Registered unsigned product |

## Verification
The bench drives an operand with only one nonzero nibble against a single nonzero nibble in the other operand. This isolates each nibble weight. A swapped or missing shift then shows up as a product that is 16 or 256 times too large or too small. The all-ones pair exercises the top entry of the tables and the full carry into bit 15. A truncated table or a narrow sum would return a wrapped value there. Operands changed while the strobe is low catch a register that loads on every cycle. The exhaustive back-to-back sweep catches a one-cycle skew between the product and the flag, or a dropped back-to-back result.

// File: rtl/nlm_pkg.sv
package nlm_pkg;
  localparam int NIB_W_DEF = 4;
  localparam int NIBS_DEF  = 2;

  // product of two small unsigned indices, used to fill each table
  function automatic int unsigned nib_product(int unsigned x, int unsigned y);
    return x * y;
  endfunction

  // weight (as a left shift) of pairing nibble i of A with nibble j of B
  function automatic int unsigned pair_shift(int unsigned i, int unsigned j, int unsigned nw);
    return (i + j) * nw;
  endfunction
endpackage

// File: rtl/nlm_nib_rom.sv
module nlm_nib_rom #(
  parameter int NW = 4
) (
  input  logic [NW-1:0]   a_nib,
  input  logic [NW-1:0]   b_nib,
  output logic [2*NW-1:0] prod
);
  localparam int PW    = 2 * NW;
  localparam int DEPTH = 1 << PW;

  logic [PW-1:0] rom [DEPTH];

  // entry index = {a_nib, b_nib}; contents computed at elaboration
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign rom[k] = PW'(nlm_pkg::nib_product(k >> NW, k % (1 << NW)));
  end

  assign prod = rom[{a_nib, b_nib}];
endmodule

// File: rtl/nlm_pp_sum.sv
module nlm_pp_sum #(
  parameter int NW   = 4,
  parameter int NIBS = 2
) (
  input  logic [NIBS*NIBS*2*NW-1:0] pp_flat,
  output logic [2*NIBS*NW-1:0]      sum
);
  localparam int PW = 2 * NW;
  localparam int RW = 2 * NIBS * NW;
  localparam int NP = NIBS * NIBS;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NP; k++) begin
      sum = sum + (RW'(pp_flat[k*PW +: PW]) << nlm_pkg::pair_shift(k / NIBS, k % NIBS, NW));
    end
  end
endmodule

// File: rtl/nibble_lut_mult.sv
module nibble_lut_mult #(
  parameter int NW   = nlm_pkg::NIB_W_DEF,
  parameter int NIBS = nlm_pkg::NIBS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NW*NIBS-1:0]   op_a,
  input  logic [NW*NIBS-1:0]   op_b,
  output logic                 out_valid,
  output logic [2*NW*NIBS-1:0] out_prod
);
  localparam int PW = 2 * NW;
  localparam int RW = 2 * NW * NIBS;
  localparam int NP = NIBS * NIBS;

  logic [NW-1:0]    a_nib [NIBS];
  logic [NW-1:0]    b_nib [NIBS];
  logic [PW-1:0]    pp    [NP];
  logic [NP*PW-1:0] pp_flat;
  logic [RW-1:0]    prod_comb;
  logic             load_en;

  for (genvar i = 0; i < NIBS; i++) begin : g_split
    assign a_nib[i] = op_a[i*NW +: NW];
    assign b_nib[i] = op_b[i*NW +: NW];
  end

  // slot i*NIBS+j holds (nibble i of A) x (nibble j of B)
  for (genvar i = 0; i < NIBS; i++) begin : g_row
    for (genvar j = 0; j < NIBS; j++) begin : g_col
      nlm_nib_rom #(.NW(NW)) u_rom (
        .a_nib (a_nib[i]),
        .b_nib (b_nib[j]),
        .prod  (pp[i*NIBS+j])
      );
      assign pp_flat[(i*NIBS+j)*PW +: PW] = pp[i*NIBS+j];
    end
  end

  nlm_pp_sum #(.NW(NW), .NIBS(NIBS)) u_sum (
    .pp_flat (pp_flat),
    .sum     (prod_comb)
  );

  assign load_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) out_prod <= prod_comb;
    end
  end
endmodule

// File: rtl/nlm_chk.sv
module nlm_chk #(
  parameter int NW   = 4,
  parameter int NIBS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic [NW*NIBS-1:0]           op_a,
  input logic [NW*NIBS-1:0]           op_b,
  input logic                         out_valid,
  input logic [2*NW*NIBS-1:0]         out_prod,
  input logic [NIBS*NIBS*2*NW-1:0]    pp_flat
);
  localparam int OW = NW * NIBS;
  localparam int RW = 2 * OW;
  localparam int PW = 2 * NW;
  localparam logic [RW-1:0] MAXP = RW'(((1 << OW) - 1) * ((1 << OW) - 1));

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) p_reset_zero_r1: assert (out_valid == 1'b0 && out_prod == '0);
  end

  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid |=> out_valid);
  p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !in_valid |=> !out_valid);

  p_prod_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid |=> out_prod == RW'($past(op_a)) * RW'($past(op_b)));

  p_prod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !in_valid |=> $stable(out_prod));

  for (genvar i = 0; i < NIBS; i++) begin : g_ti
    for (genvar j = 0; j < NIBS; j++) begin : g_tj
      p_table_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pp_flat[(i*NIBS+j)*PW +: PW] == PW'(op_a[i*NW +: NW]) * PW'(op_b[j*NW +: NW]));
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_prod <= MAXP);
endmodule

bind nibble_lut_mult nlm_chk #(.NW(NW), .NIBS(NIBS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .pp_flat   (pp_flat)
);

// File: tb/tb_nibble_lut_mult.sv
module tb_nibble_lut_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        out_valid;
  logic [15:0] out_prod;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  nibble_lut_mult dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .op_a (op_a), .op_b (op_b), .out_valid (out_valid), .out_prod (out_prod)
  );

  // reference: shift-and-add over the bits of a
  function automatic logic [15:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (a[i]) acc = acc + (16'(b) << i);
    return acc;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one strobed pair and check the product one cycle later
  task automatic one_shot(string req, logic [7:0] a, logic [7:0] b, logic [15:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {16'd0, out_prod}, {16'd0, exp});
    chk(req, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 prod", {16'd0, out_prod}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_table;
    one_shot("R5 (1,1)", 8'h01, 8'h01, 16'd1);
    one_shot("R5 (3,3)", 8'h03, 8'h03, 16'd9);
    one_shot("R5 (15,15)", 8'h0F, 8'h0F, 16'd225);
  endtask

  task automatic t_weights;
    one_shot("R6 lo*lo", 8'h0A, 8'h0C, 16'd120);
    one_shot("R6 hi*lo", 8'hA0, 8'h0C, 16'd1920);
    one_shot("R6 lo*hi", 8'h0A, 8'hC0, 16'd1920);
    one_shot("R6 hi*hi", 8'hA0, 8'hC0, 16'd30720);
  endtask

  task automatic t_corners;
    one_shot("R7 max", 8'hFF, 8'hFF, 16'hFE01);
    one_shot("R7 zero a", 8'h00, 8'hFF, 16'd0);
    one_shot("R7 zero b", 8'hFF, 8'h00, 16'd0);
  endtask

  task automatic t_hold;
    one_shot("R4 load", 8'd12, 8'd13, 16'd156);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op_a = 8'(8'hF0 + k); op_b = 8'hEE;
      in_valid = 1'b0;
      @(negedge clk);
      chk("R4 hold prod", {16'd0, out_prod}, 32'd156);
      chk("R4 hold valid", {31'd0, out_valid}, 0);
    end
  endtask

  task automatic t_valid_pattern;
    logic pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      op_a = 8'(k + 3); op_b = 8'(k + 7); in_valid = pat[k];
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 latency", {31'd0, out_valid}, {31'd0, pat[k]});
    end
  endtask

  task automatic t_sweep;
    logic [15:0] exp_prev = '0;
    bit have = 1'b0;
    for (int n = 0; n < 65536; n++) begin
      @(negedge clk);
      if (have) begin
        chk("R8 sweep", {16'd0, out_prod}, {16'd0, exp_prev});
        if (!out_valid) chk("R2 sweep valid", 0, 1);
      end
      op_a = 8'(n >> 8); op_b = 8'(n); in_valid = 1'b1;
      exp_prev = ref_mul(8'(n >> 8), 8'(n));
      have = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 last", {16'd0, out_prod}, {16'd0, exp_prev});
  endtask

  initial begin
    t_reset();
    t_table();
    t_weights();
    t_corners();
    t_hold();
    t_valid_pattern();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule